// File: doc/BRIEF.md
# Paged Address Translation With Protection

This block sits between the bus masters and memory. It splits a 20-bit logical address into a page number and an offset. The page number selects one of 256 table entries. Each entry holds a physical page number and five permission flags. The physical page number replaces the upper eight address bits, and the requesting master, the current user/system mode and the access type are checked against the flags. Every access result (physical address, grant and one pulse for each kind of violation) appears one clock after the request. Reads from the top 8 KB of the logical space go to boot ROM and skip both translation and checking.

Software fills the table through a 16-bit I/O window of even addresses. The entry for page N sits at address 200H + 2N. A read through the window returns the stored entry one cycle later.

Top module: `page_xlate`

## Requirements
- R1: For a valid access outside the ROM-read case, phys_addr one cycle later equals {entry page number, logical address bits 11..0}, where the entry is selected by logical address bits 19..12.
- R2: A valid read (acc_write=0) with logical address in FE000H..FFFFFH gives phys_addr equal to the logical address, rom_sel=1, acc_grant=1 and no violation, whatever the entry holds. Writes to that range are translated and checked as usual.
- R3: A valid I/O write to even address 200H+2N, for N from 0 to 255, stores io_wdata bits 7..0 as page N's physical page number and bits 15..11 as its flags. Bit 11 allows other-master writes, bit 12 allows system-mode CPU writes, bit 13 marks a stack-boundary page, bit 14 allows user-mode access and bit 15 allows user-mode writes.
- R4: io_rdata is registered. It holds {bits 15..11 flags, 000, physical page number} one cycle after a valid I/O read of an even window address, and zero otherwise. A write to an odd address or to an address outside the window changes no entry.
- R5: A CPU access (acc_master=0) in user mode to a page whose bit 14 is clear pulses v_user_acc.
- R6: A CPU write in user mode to a page with bit 14 set and bit 15 clear pulses v_user_wr.
- R7: A CPU write in system mode to a page with bit 12 clear pulses v_sys_wr.
- R8: A write from another master (acc_master=1) to a page with bit 11 clear pulses v_other_wr. user_mode and bit 14 do not affect other masters.
- R9: A write with acc_push=1 to a page with bit 13 set, whose offset is below 128, pulses v_stack.
- R10: acc_grant is 1 one cycle after a valid access that raised no violation. When the previous cycle had no valid access, acc_grant, rom_sel, phys_addr and every violation output are 0.
- R11: An access made in the same cycle as an I/O write to its own entry uses the entry as it was before that write.
- R12: During and just after reset all outputs are zero and every entry reads back as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Memory access request |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_push | input | 1 | Write is a stack push |
| acc_master | input | 1 | 0 = main CPU, 1 = other bus master |
| user_mode | input | 1 | CPU is in user mode |
| log_addr | input | 20 | Logical address |
| phys_addr | output | 20 | Physical address, one cycle later |
| acc_grant | output | 1 | Access allowed |
| rom_sel | output | 1 | Access is a boot ROM read |
| v_user_acc | output | 1 | User access violation pulse |
| v_user_wr | output | 1 | User write violation pulse |
| v_sys_wr | output | 1 | System write violation pulse |
| v_other_wr | output | 1 | Other-master write violation pulse |
| v_stack | output | 1 | End-of-stack violation pulse |
| io_valid | input | 1 | I/O window request |
| io_write | input | 1 | 1 = I/O write, 0 = I/O read |
| io_addr | input | 16 | I/O address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, one cycle later |

## Verification
An access and an update of the table can land in the same cycle, including when both target the same page. The bench provokes this on purpose in a directed step: it rewrites a page's entry while an access to that page is in flight. It also lets the two collide freely during a long random run that mixes table writes, reads and accesses. A behavioural model decides the result. It evaluates the access against its copy of the table first, and applies the write only afterwards. Every output is then compared on every clock.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int LA_W        = 20,
  parameter int PG_W        = 8,
  parameter int IO_W        = 16,
  parameter int GUARD_BYTES = 128,
  parameter int ROM_SHIFT   = 1,
  parameter logic [IO_W-1:0] WIN_BASE = 16'h0200,
  parameter logic [PG_W-1:0] ROM_PAGE = 8'hFE
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acc_valid,
  input  logic            acc_write,
  input  logic            acc_push,
  input  logic            acc_master,
  input  logic            user_mode,
  input  logic [LA_W-1:0] log_addr,
  output logic [LA_W-1:0] phys_addr,
  output logic            acc_grant,
  output logic            rom_sel,
  output logic            v_user_acc,
  output logic            v_user_wr,
  output logic            v_sys_wr,
  output logic            v_other_wr,
  output logic            v_stack,
  input  logic            io_valid,
  input  logic            io_write,
  input  logic [IO_W-1:0] io_addr,
  input  logic [IO_W-1:0] io_wdata,
  output logic [IO_W-1:0] io_rdata
);
  localparam int OFS_W   = LA_W - PG_W;
  localparam int NPAGE   = 1 << PG_W;
  localparam int GUARD_W = $clog2(GUARD_BYTES);
  localparam int FLG_W   = 5;
  localparam int PAD_W   = IO_W - FLG_W - PG_W;
  localparam logic [IO_W-1:0] WIN_END = WIN_BASE + IO_W'(2 * NPAGE);

  // flag bit order inside an entry
  localparam int F_OTHER = 0;
  localparam int F_SYS   = 1;
  localparam int F_STACK = 2;
  localparam int F_UACC  = 3;
  localparam int F_UWR   = 4;

  logic [PG_W-1:0]  ppn_q  [NPAGE];
  logic [FLG_W-1:0] flag_q [NPAGE];

  logic [IO_W-1:0] win_off;
  logic            in_win, wr_hit, rd_hit;
  logic [PG_W-1:0] widx;

  assign win_off = io_addr - WIN_BASE;
  assign in_win  = io_valid && !io_addr[0] && io_addr >= WIN_BASE && io_addr < WIN_END;
  assign widx    = win_off[PG_W:1];
  assign wr_hit  = in_win && io_write;
  assign rd_hit  = in_win && !io_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NPAGE; i++) begin
        ppn_q[i]  <= '0;
        flag_q[i] <= '0;
      end
    end else if (wr_hit) begin
      ppn_q[widx]  <= io_wdata[PG_W-1:0];
      flag_q[widx] <= io_wdata[IO_W-1 -: FLG_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) io_rdata <= '0;
    else if (rd_hit) io_rdata <= {flag_q[widx], {PAD_W{1'b0}}, ppn_q[widx]};
    else io_rdata <= '0;
  end

  logic [PG_W-1:0]  pg, ppn;
  logic [FLG_W-1:0] fl;
  logic             cpu, rom_rd, chk;
  logic             n_uacc, n_uwr, n_sys, n_oth, n_stk;

  assign pg     = log_addr[LA_W-1:OFS_W];
  assign ppn    = ppn_q[pg];
  assign fl     = flag_q[pg];
  assign cpu    = !acc_master;
  assign rom_rd = !acc_write && (pg[PG_W-1:ROM_SHIFT] == ROM_PAGE[PG_W-1:ROM_SHIFT]);
  assign chk    = acc_valid && !rom_rd;

  assign n_uacc = chk && cpu && user_mode && !fl[F_UACC];
  assign n_uwr  = chk && cpu && user_mode && acc_write && fl[F_UACC] && !fl[F_UWR];
  assign n_sys  = chk && cpu && !user_mode && acc_write && !fl[F_SYS];
  assign n_oth  = chk && !cpu && acc_write && !fl[F_OTHER];
  assign n_stk  = chk && acc_write && acc_push && fl[F_STACK] &&
                  (log_addr[OFS_W-1:GUARD_W] == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phys_addr  <= '0;
      acc_grant  <= 1'b0;
      rom_sel    <= 1'b0;
      v_user_acc <= 1'b0;
      v_user_wr  <= 1'b0;
      v_sys_wr   <= 1'b0;
      v_other_wr <= 1'b0;
      v_stack    <= 1'b0;
    end else begin
      phys_addr  <= !acc_valid ? '0 : rom_rd ? log_addr : {ppn, log_addr[OFS_W-1:0]};
      rom_sel    <= acc_valid && rom_rd;
      acc_grant  <= acc_valid && !(n_uacc || n_uwr || n_sys || n_oth || n_stk);
      v_user_acc <= n_uacc;
      v_user_wr  <= n_uwr;
      v_sys_wr   <= n_sys;
      v_other_wr <= n_oth;
      v_stack    <= n_stk;
    end
  end

  // R1
  offset_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) |-> phys_addr[OFS_W-1:0] == $past(log_addr[OFS_W-1:0]));

  // R2
  rom_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid && !acc_write && log_addr[LA_W-1:LA_W-PG_W+ROM_SHIFT] == ROM_PAGE[PG_W-1:ROM_SHIFT])
    |-> rom_sel && acc_grant && phys_addr == $past(log_addr));

  // R4
  rdata_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata[IO_W-FLG_W-1:PG_W] == '0);

  // R4
  odd_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(io_valid && io_addr[0]) |-> io_rdata == '0);

  // R6
  user_wr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_user_wr |-> $past(acc_write && user_mode && !acc_master));

  // R9
  stack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_stack |-> $past(acc_push && acc_write && log_addr[OFS_W-1:GUARD_W] == '0));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> !acc_grant && !rom_sel && phys_addr == '0 &&
                   !(v_user_acc || v_user_wr || v_sys_wr || v_other_wr || v_stack));

  // R10
  grant_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_grant |-> $past(acc_valid));
endmodule

// File: tb/page_xlate_bench.sv
module page_xlate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        av = 0, aw = 0, ap = 0, am = 0, um = 0;
  logic [19:0] la = '0;
  logic        iv = 0, iw = 0;
  logic [15:0] ia = '0, iwd = '0;

  logic [19:0] phys_addr;
  logic        acc_grant, rom_sel, v_user_acc, v_user_wr, v_sys_wr, v_other_wr, v_stack;
  logic [15:0] io_rdata;

  page_xlate u_page_xlate (
    .clk(clk), .rst_n(rst_n),
    .acc_valid(av), .acc_write(aw), .acc_push(ap), .acc_master(am), .user_mode(um),
    .log_addr(la), .phys_addr(phys_addr), .acc_grant(acc_grant), .rom_sel(rom_sel),
    .v_user_acc(v_user_acc), .v_user_wr(v_user_wr), .v_sys_wr(v_sys_wr),
    .v_other_wr(v_other_wr), .v_stack(v_stack),
    .io_valid(iv), .io_write(iw), .io_addr(ia), .io_wdata(iwd), .io_rdata(io_rdata)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string ctx = "";

  logic [7:0]  mppn [256];
  logic [4:0]  mflg [256];
  logic [19:0] e_phys;
  logic        e_grant, e_rom, e_uacc, e_uwr, e_sys, e_oth, e_stk;
  logic [15:0] e_rd;

  task automatic chk(bit ok, string tag, logic [19:0] act, logic [19:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s%s%s: actual=%h expected=%h at %0t", ctx, (ctx != "") ? "/" : "", tag, act, exp, $time);
    end
  endtask

  function automatic bit win(logic [15:0] a);
    return a >= 16'h0200 && a <= 16'h03FE && !a[0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin mppn[i] = '0; mflg[i] = '0; end
      e_phys = '0; e_grant = 0; e_rom = 0; e_uacc = 0; e_uwr = 0;
      e_sys = 0; e_oth = 0; e_stk = 0; e_rd = '0;
    end else begin
      automatic logic [7:0] pg = la[19:12];
      automatic logic [4:0] f = mflg[pg];
      automatic bit cpu = !am;
      automatic bit rom = av && !aw && pg >= 8'hFE;
      automatic bit ck = av && !rom;
      automatic int ix = (int'(ia) - 'h200) / 2;
      e_rom  = rom;
      e_phys = !av ? '0 : rom ? la : {mppn[pg], la[11:0]};
      e_uacc = ck && cpu && um && !f[3];
      e_uwr  = ck && cpu && um && aw && f[3] && !f[4];
      e_sys  = ck && cpu && !um && aw && !f[1];
      e_oth  = ck && !cpu && aw && !f[0];
      e_stk  = ck && aw && ap && f[2] && la[11:0] < 128;
      e_grant = av && !(e_uacc || e_uwr || e_sys || e_oth || e_stk);
      e_rd = (iv && !iw && win(ia)) ? {mflg[ix], 3'b000, mppn[ix]} : '0;
      if (iv && iw && win(ia)) begin
        mppn[ix] = iwd[7:0];
        mflg[ix] = iwd[15:11];
      end
    end
    #1;
    chk(phys_addr == e_phys, e_rom ? "R2" : "R1", phys_addr, e_phys);
    chk(rom_sel == e_rom, "R2", 20'(rom_sel), 20'(e_rom));
    chk(acc_grant == e_grant, "R10", 20'(acc_grant), 20'(e_grant));
    chk(v_user_acc == e_uacc, "R5", 20'(v_user_acc), 20'(e_uacc));
    chk(v_user_wr == e_uwr, "R6", 20'(v_user_wr), 20'(e_uwr));
    chk(v_sys_wr == e_sys, "R7", 20'(v_sys_wr), 20'(e_sys));
    chk(v_other_wr == e_oth, "R8", 20'(v_other_wr), 20'(e_oth));
    chk(v_stack == e_stk, "R9", 20'(v_stack), 20'(e_stk));
    chk(io_rdata == e_rd, "R4", 20'(io_rdata), 20'(e_rd));
  end

  task automatic drive(bit v, bit w, bit p, bit m, bit u, logic [19:0] a,
                       bit i_v, bit i_w, logic [15:0] i_a, logic [15:0] i_d);
    @(negedge clk);
    av = v; aw = w; ap = p; am = m; um = u; la = a;
    iv = i_v; iw = i_w; ia = i_a; iwd = i_d;
  endtask

  task automatic idle();
    drive(0, 0, 0, 0, 0, '0, 0, 0, '0, '0);
  endtask

  task automatic setpg(logic [7:0] n, logic [15:0] d);
    drive(0, 0, 0, 0, 0, '0, 1, 1, 16'h0200 + {7'd0, n, 1'b0}, d);
  endtask

  task automatic acc(bit w, bit p, bit m, bit u, logic [19:0] a);
    drive(1, w, p, m, u, a, 0, 0, '0, '0);
  endtask

  initial begin
    ctx = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0, '0, 1, 0, 16'h0200, '0);
    drive(0, 0, 0, 0, 0, '0, 1, 0, 16'h03FE, '0);
    idle();

    ctx = "R3";
    setpg(8'h34, 16'hFFA5);
    drive(0, 0, 0, 0, 0, '0, 1, 0, 16'h0268, '0);
    acc(0, 0, 0, 0, 20'h34ABC);
    ctx = "R4";
    drive(0, 0, 0, 0, 0, '0, 1, 1, 16'h0269, 16'h1234);
    drive(0, 0, 0, 0, 0, '0, 1, 1, 16'h0400, 16'h1234);
    drive(0, 0, 0, 0, 0, '0, 1, 0, 16'h0269, '0);
    drive(0, 0, 0, 0, 0, '0, 1, 0, 16'h0268, '0);

    ctx = "R5";
    setpg(8'h10, 16'h0011);
    acc(0, 0, 0, 1, 20'h10123);
    acc(0, 0, 1, 1, 20'h10123);
    ctx = "R6";
    setpg(8'h11, 16'h4022);
    acc(1, 0, 0, 1, 20'h11FFF);
    acc(0, 0, 0, 1, 20'h11FFF);
    ctx = "R7";
    setpg(8'h12, 16'hE833);
    acc(1, 0, 0, 0, 20'h12000);
    ctx = "R8";
    setpg(8'h13, 16'h1044);
    acc(1, 0, 1, 1, 20'h13456);
    acc(1, 0, 0, 0, 20'h13456);
    ctx = "R9";
    setpg(8'h14, 16'h3855);
    acc(1, 1, 0, 0, 20'h1407F);
    acc(1, 1, 0, 0, 20'h14080);
    acc(1, 0, 0, 0, 20'h14000);
    ctx = "R2";
    setpg(8'hFE, 16'h0000);
    acc(0, 0, 0, 1, 20'hFE123);
    acc(0, 0, 1, 0, 20'hFFFFF);
    acc(1, 0, 0, 0, 20'hFE123);

    ctx = "R11";
    setpg(8'h05, 16'hD877);
    drive(1, 1, 0, 0, 0, 20'h05321, 1, 1, 16'h020A, 16'h0099);
    acc(1, 0, 0, 0, 20'h05321);
    idle();

    ctx = "";
    for (int n = 0; n < 4000; n++) begin
      automatic logic [19:0] a = $urandom;
      automatic int r = $urandom_range(0, 99);
      automatic logic [15:0] io_a;
      if ($urandom_range(0, 9) < 2) a[19:13] = 7'h7F;
      if ($urandom_range(0, 1) == 1) a[11:7] = '0;
      a[19:12] = (a[19:13] == 7'h7F) ? a[19:12] : {3'b000, a[16:12]};
      io_a = (r < 70) ? 16'h0200 + {7'd0, 8'($urandom), 1'b0}
           : (r < 85) ? (16'h0201 + {7'd0, 8'($urandom), 1'b0}) : 16'($urandom);
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 3) == 0, $urandom_range(0, 1), a,
            $urandom_range(0, 2) == 0, $urandom_range(0, 1), io_a, 16'($urandom));
    end
    idle();
    idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule